// File: doc/BRIEF.md
# GPIO Event Trigger Generator

This block sits beside the pin logic of a general-purpose I/O port and turns pin activity into hardware triggers. Each pin is brought through a two-stage synchronizer and then watched for a configured event. A pin can look for an edge or for a level, and for either polarity. A qualifying event can fire a one-clock start pulse toward an ADC sequencer and a one-clock request strobe toward a DMA controller. It also sets a bit in a raw interrupt status word.

A level source behaves like an edge source as far as the ADC is concerned. While the level stays asserted, only one start pulse comes out. The next pulse needs the level to drop and return. For ports whose ADC enable word is entirely zero, one fixed pin still drives the ADC start on its own, so older firmware keeps working. The DMA controller's completion handshake comes back into the block as a dedicated status bit. Status bits are cleared by writing ones. An event arriving in the same cycle as the clear takes precedence.

Top module: `gpio_evt_trig`

## Requirements
- R1: A change on `pin_in` is first reflected in `raw_stat`, `adc_trig` or `dma_req` at the third rising clock edge after it is applied, because of two synchronizer stages and one output register.
- R2: With `lvl_mode[i]`=0 (edge detection), `pol_hi[i]`=1 selects rising edges and `pol_hi[i]`=0 selects falling edges. A selected edge sets `raw_stat[i]` once.
- R3: With `lvl_mode[i]`=1 (level detection), `raw_stat[i]` is set on every cycle in which the synchronized pin equals `pol_hi[i]`. While that level is held, a clear of that bit does not stay in effect.
- R4: `adc_trig` is never high on two consecutive clock cycles.
- R5: In level detection, a level held asserted yields exactly one `adc_trig` pulse. A new pulse requires the level to go inactive and become active again.
- R6: Pin i is an ADC trigger source when `adc_en[i]`=1. Events on several enabled pins in the same cycle produce a single one-cycle pulse.
- R7: When `adc_en` is all zero, an event on pin `LEGACY_PIN` (default 4) still fires `adc_trig`. When any `adc_en` bit is set, that pin triggers only through its own enable.
- R8: `dma_req[i]` pulses for one cycle on an event of pin i only when both `dma_en[i]` and `int_mask[i]` are 1.
- R9: A high `dma_done` at a clock edge sets `raw_stat[NPIN]`, the DMA-done bit.
- R10: `msk_stat` equals `raw_stat` AND `int_mask` bit by bit, including the DMA-done bit at position NPIN.
- R11: A 1 in `stat_clr[b]` for one cycle clears `raw_stat[b]`. If the same bit is being set in that cycle, it stays 1.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Raw pin values |
| lvl_mode | input | NPIN | 1 = level detection, 0 = edge detection |
| pol_hi | input | NPIN | 1 = rising/high, 0 = falling/low |
| int_mask | input | NPIN+1 | Interrupt mask; bit NPIN masks DMA done |
| adc_en | input | NPIN | Per-pin ADC trigger enable |
| dma_en | input | NPIN | Per-pin DMA trigger enable |
| dma_done | input | 1 | Completion strobe from DMA controller |
| stat_clr | input | NPIN+1 | Write-one-to-clear strobe for status |
| adc_trig | output | 1 | One-cycle ADC start pulse |
| dma_req | output | NPIN | One-cycle DMA request per pin |
| raw_stat | output | NPIN+1 | Raw interrupt status |
| msk_stat | output | NPIN+1 | Masked interrupt status |

## Verification
The two functions that can land in the same cycle are setting a status bit and clearing it. This happens for a pin event, or a DMA completion, that coincides with a write-one-to-clear of the same bit. Random traffic drives sparse clear strobes and `dma_done` pulses against toggling pins, so these collisions occur many times. A directed case forces `dma_done` and a clear of the done bit into the very same cycle. Each cycle, a reference model computed from the requirements predicts the status word, and the bench compares against it. The set must win whenever the two meet.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } det_mode_e;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_d, stg2_d;

  always_comb begin
    stg1_d = din;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign dout = stg2_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_s,
  input  logic [NPIN-1:0] lvl_mode,
  input  logic [NPIN-1:0] pol_hi,
  output logic [NPIN-1:0] hit,
  output logic [NPIN-1:0] stat_set
);

  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] prev_d;

  assign prev_d = pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic      on_lvl;
    logic      moved;
    det_mode_e mode;

    always_comb begin
      mode   = det_mode_e'(lvl_mode[i]);
      on_lvl = (pin_s[i] == pol_hi[i]);
      moved  = (pin_s[i] != prev_q[i]);
      // entering the active state: an edge, or the start of a level
      hit[i] = moved & on_lvl;
      case (mode)
        DET_LEVEL: stat_set[i] = on_lvl;
        default:   stat_set[i] = moved & on_lvl;
      endcase
    end
  end

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set,
  input  logic [SW-1:0] clr,
  input  logic [SW-1:0] mask,
  output logic [SW-1:0] raw,
  output logic [SW-1:0] msk
);

  logic [SW-1:0] raw_q, raw_d;
  logic          upd_en;

  always_comb begin
    upd_en = (|set) | (|clr);
    raw_d  = (raw_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw_q <= '0;
    else if (upd_en) raw_q <= raw_d;
  end

  assign raw = raw_q;
  assign msk = raw_q & mask;

endmodule

// File: rtl/gpio_evt_trig.sv
module gpio_evt_trig #(
  parameter int NPIN       = 8,
  parameter int LEGACY_PIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] lvl_mode,
  input  logic [NPIN-1:0] pol_hi,
  input  logic [NPIN:0]   int_mask,
  input  logic [NPIN-1:0] adc_en,
  input  logic [NPIN-1:0] dma_en,
  input  logic            dma_done,
  input  logic [NPIN:0]   stat_clr,
  output logic            adc_trig,
  output logic [NPIN-1:0] dma_req,
  output logic [NPIN:0]   raw_stat,
  output logic [NPIN:0]   msk_stat
);

  localparam int SW = NPIN + 1;

  logic [NPIN-1:0] pin_s;
  logic [NPIN-1:0] hit;
  logic [NPIN-1:0] pin_set;
  logic [SW-1:0]   all_set;

  logic            adc_src, legacy_src;
  logic            adc_q, adc_d;
  logic [NPIN-1:0] dma_q, dma_d;

  gpio_evt_sync #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_s)
  );

  gpio_evt_detect #(.NPIN(NPIN)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_s   (pin_s),
    .lvl_mode(lvl_mode),
    .pol_hi  (pol_hi),
    .hit     (hit),
    .stat_set(pin_set)
  );

  assign all_set = {dma_done, pin_set};

  gpio_evt_status #(.SW(SW)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (all_set),
    .clr  (stat_clr),
    .mask (int_mask),
    .raw  (raw_stat),
    .msk  (msk_stat)
  );

  if (LEGACY_PIN >= 0 && LEGACY_PIN < NPIN) begin : g_legacy
    assign legacy_src = (adc_en == '0) & hit[LEGACY_PIN];
  end else begin : g_no_legacy
    assign legacy_src = 1'b0;
  end

  always_comb begin
    adc_src = (|(hit & adc_en)) | legacy_src;
    adc_d   = adc_src & ~adc_q;
    dma_d   = hit & dma_en & int_mask[NPIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_q <= 1'b0;
      dma_q <= '0;
    end else begin
      adc_q <= adc_d;
      dma_q <= dma_d;
    end
  end

  assign adc_trig = adc_q;
  assign dma_req  = dma_q;

endmodule

// File: rtl/gpio_evt_trig_chk.sv
module gpio_evt_trig_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_trig,
  input logic [NPIN-1:0] dma_req,
  input logic [NPIN-1:0] dma_en,
  input logic [NPIN-1:0] pin_mask,
  input logic            dma_done,
  input logic            done_clr,
  input logic            done_raw
);

  // R4
  adc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |=> !adc_trig);

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> done_raw);

  // R11
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !dma_done) |=> !done_raw);

  for (genvar i = 0; i < NPIN; i++) begin : g_dma
    // R8
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[i] |-> $past(dma_en[i] && pin_mask[i]));
  end

endmodule

bind gpio_evt_trig gpio_evt_trig_chk #(.NPIN(NPIN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .adc_trig(adc_trig),
  .dma_req (dma_req),
  .dma_en  (dma_en),
  .pin_mask(int_mask[NPIN-1:0]),
  .dma_done(dma_done),
  .done_clr(stat_clr[NPIN]),
  .done_raw(raw_stat[NPIN])
);

// File: tb/gpio_evt_trig_bench.sv
module gpio_evt_trig_bench;
  localparam int N   = 8;
  localparam int LEG = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0, lvl_mode = '0, pol_hi = '0, adc_en = '0, dma_en = '0;
  logic [N:0]   int_mask = '0, stat_clr = '0;
  logic         dma_done = 1'b0;
  logic         adc_trig;
  logic [N-1:0] dma_req;
  logic [N:0]   raw_stat, msk_stat;

  int total = 0, bad = 0;
  int npulse = 0, ndma = 0;
  bit chk_on = 0;
  logic adc_prev = 1'b0;

  // reference model state
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_dma = '0;
  logic [N:0]   m_raw = '0;
  logic         m_adc = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_trig #(.NPIN(N), .LEGACY_PIN(LEG)) u_gpio_evt_trig (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvl_mode(lvl_mode),
    .pol_hi(pol_hi), .int_mask(int_mask), .adc_en(adc_en), .dma_en(dma_en),
    .dma_done(dma_done), .stat_clr(stat_clr), .adc_trig(adc_trig),
    .dma_req(dma_req), .raw_stat(raw_stat), .msk_stat(msk_stat)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected-value functions derived from the requirements
  function automatic logic [N-1:0] f_hit(logic [N-1:0] cur, logic [N-1:0] old, logic [N-1:0] pol);
    return (cur ^ old) & ~(cur ^ pol);
  endfunction

  function automatic logic [N-1:0] f_set(logic [N-1:0] cur, logic [N-1:0] old,
                                          logic [N-1:0] pol, logic [N-1:0] lvl);
    logic [N-1:0] on = ~(cur ^ pol);
    return (lvl & on) | (~lvl & f_hit(cur, old, pol));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_dma = '0; m_raw = '0; m_adc = 1'b0;
    end else begin
      logic [N-1:0] h;
      logic src;
      h = f_hit(m_s2, m_prev, pol_hi);
      m_raw = (m_raw & ~stat_clr) | {dma_done, f_set(m_s2, m_prev, pol_hi, lvl_mode)};
      src = (|(h & adc_en)) | ((adc_en == '0) && h[LEG]);
      m_adc = src && !m_adc;
      m_dma = h & dma_en & int_mask[N-1:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 R6 R7 adc_trig vs model", {31'd0, adc_trig}, {31'd0, m_adc});
      chk("R8 dma_req vs model", {24'd0, dma_req}, {24'd0, m_dma});
      chk("R2 R3 R9 R11 raw_stat vs model", {23'd0, raw_stat}, {23'd0, m_raw});
      chk("R10 msk_stat", {23'd0, msk_stat}, {23'd0, m_raw & int_mask});
      chk("R4 no back-to-back trigger", {31'd0, adc_trig & adc_prev}, 32'd0);
      if (adc_trig) npulse++;
      if (dma_req[0]) ndma++;
    end
    adc_prev = adc_trig;
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd51234));
    step(3);
    // R12 reset state
    chk("R12 adc_trig in reset", {31'd0, adc_trig}, 0);
    chk("R12 dma_req in reset", {24'd0, dma_req}, 0);
    chk("R12 raw_stat in reset", {23'd0, raw_stat}, 0);
    rst_n = 1'b1;
    chk_on = 1;
    int_mask = '1;
    pol_hi = '1;
    step(4);

    // R5 level held gives one trigger; R3 clear does not stick
    lvl_mode = 8'h02; adc_en = 8'h02; npulse = 0;
    pin_in[1] = 1'b1; step(20);
    chk("R5 one pulse on held level", npulse, 1);
    stat_clr[1] = 1'b1; step(1); stat_clr = '0; step(1);
    chk("R3 level bit re-set after clear", {31'd0, raw_stat[1]}, 1);
    pin_in[1] = 1'b0; step(6); npulse = 0;
    pin_in[1] = 1'b1; step(8);
    chk("R5 re-arm after level drop", npulse, 1);
    pin_in = '0; lvl_mode = '0; step(6);

    // R7 legacy path
    adc_en = '0; npulse = 0;
    pin_in[LEG] = 1'b1; step(6);
    chk("R7 legacy pin fires with zero enables", npulse, 1);
    pin_in[2] = 1'b1; step(6);
    chk("R7 non-legacy pin ignored", npulse, 1);
    pin_in = '0; adc_en = 8'h04; step(6); npulse = 0;
    pin_in[LEG] = 1'b1; step(6);
    chk("R7 legacy off when any enable set", npulse, 0);
    pin_in = '0; step(6);

    // R6 simultaneous sources merge
    adc_en = 8'h03; npulse = 0;
    pin_in[1:0] = 2'b11; step(6);
    chk("R6 simultaneous pins one pulse", npulse, 1);
    pin_in = '0; adc_en = '0; step(6);

    // R8 DMA gating by mask
    dma_en = 8'h01; int_mask[0] = 1'b0; ndma = 0;
    pin_in[0] = 1'b1; step(6);
    chk("R8 masked pin no request", ndma, 0);
    pin_in[0] = 1'b0; int_mask[0] = 1'b1; step(6);
    pin_in[0] = 1'b1; step(6);
    chk("R8 unmasked pin one request", ndma, 1);
    pin_in = '0; dma_en = '0; step(6);

    // R9 R11 done set collides with clear
    dma_done = 1'b1; stat_clr[N] = 1'b1; step(1);
    dma_done = 1'b0; stat_clr = '0; step(1);
    chk("R11 set wins over clear (R9)", {31'd0, raw_stat[N]}, 1);
    stat_clr[N] = 1'b1; step(1); stat_clr = '0; step(1);
    chk("R11 clear alone", {31'd0, raw_stat[N]}, 0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) begin
        lvl_mode = N'($urandom); pol_hi = N'($urandom);
        adc_en = ($urandom % 4 == 0) ? '0 : N'($urandom);
        dma_en = N'($urandom); int_mask = (N+1)'($urandom);
      end
      if ($urandom % 3 == 0) pin_in = pin_in ^ N'($urandom & $urandom);
      stat_clr = ($urandom % 4 == 0) ? (N+1)'($urandom) : '0;
      dma_done = ($urandom % 8 == 0);
      step(1);
    end
    stat_clr = '0; dma_done = 1'b0;
    step(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule